// File: doc/BRIEF.md
# Shared Prescaler Tick Generator

This block turns one input clock into five independent clock-enable streams, one per timer channel. Each stream is a run of single-cycle high pulses on the input clock domain, so downstream counters stay fully synchronous and no derived clock is ever produced. The rate of each stream comes from two configuration words that the surrounding register logic presents as plain inputs.

Rates are set in two stages. Two 8-bit prescalers sit in the first configuration word. The first prescaler feeds channels 0 and 1, and the second feeds channels 2, 3 and 4. A down-counting state machine serves each prescaler and pulses once every (p+1) cycles. Each channel then divides its group's pulses by a power of two, 2^n, where n is a 4-bit select taken from the second configuration word. Channel x therefore ticks once every (p+1)·2^n input cycles.

The prescaler machine has two states. `PS_COUNT` holds a remaining count, and `PS_WRAP` is the single cycle that emits a pulse. Reset enters `PS_COUNT`. There are five transitions:
- count-down: `PS_COUNT`→`PS_COUNT` while more than one cycle remains.
- expire: `PS_COUNT`→`PS_WRAP` on the last cycle.
- reload: `PS_WRAP`→`PS_COUNT` when p>0.
- repeat: `PS_WRAP`→`PS_WRAP` when p=0.
- restart: any state to the reloaded state in the cycle a new prescaler value is seen.

When a field changes, every counter that depends on it restarts from zero. A new period then begins cleanly and never runs long on its first lap.

Top module: `prescaler_tick_gen`

## Requirements
- R1: While rst_n is low, every bit of tick_o is low.
- R2: Prescaler A is bits [7:0] of cfg_prescale_i and drives channels 0 and 1. Prescaler B is bits [15:8] and drives channels 2, 3 and 4. A channel ticks only in a cycle where its group's prescaler pulses.
- R3: The divider select n for channel x is bits [4x+3:4x] of cfg_select_i. It scales that channel's period by 2^n, and every value from 0 to 15 is honoured. With n=0 the channel ticks on every pulse of its prescaler.
- R4: With both configuration words steady, tick_o[x] is high in exactly one cycle of every (p+1)·2^n cycles. When that period is 1, the output stays high. Between two pulses of a prescaler with p>0, at least one cycle passes without a pulse.
- R5: A change to a prescaler field restarts that prescaler and every channel of its group. Count the first clock edge that sees the new value as cycle 1. Each such channel then ticks first in cycle (p+1)·2^n, with no pulse in cycle 1 when p>0.
- R6: A change to a channel's select alone restarts only that channel's counter. The prescaler keeps its phase. The first new tick comes within (p+1)·2^n cycles, and later ticks follow at that period.
- R7: A channel whose prescaler field and select are both unchanged keeps its cadence across another field's change. The gap between its last tick before the change and its first tick after it equals its period.
- R8: Reset takes the configuration as 0x0101 and 0. If the inputs hold those values when reset ends, nothing restarts. Every channel then ticks first in the cycle after the first clock edge following release, and every 2 cycles after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; every tick is a one-cycle enable in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prescale_i | input | 16 | Two 8-bit prescaler values: A in [7:0], B in [15:8] |
| cfg_select_i | input | 20 | Five 4-bit power-of-two selects, channel x in [4x+3:4x] |
| tick_o | output | 5 | One enable pulse stream per channel |

## Verification
The assertions take the configuration words to be synchronous to clk and to be held for at least one cycle after a change. This is because a restart is seen only as a difference from the value registered on the previous edge. The stimulus changes both words only just after a falling edge and then holds them for a whole observation window, at least two full periods of the slowest channel. The stimulus sweeps prescaler pairs and per-channel selects so that every channel in a window has a different select. It also includes changes of the B prescaler alone and of one select alone, and one window at the largest select value.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    // prescaler sequencer states
    typedef enum logic [0:0] {
        PS_COUNT = 1'b0,
        PS_WRAP  = 1'b1
    } ps_state_e;

    // which prescaler group a channel belongs to
    function automatic int unsigned group_of(input int unsigned ch, input int unsigned split);
        return (ch < split) ? 0 : 1;
    endfunction

endpackage

// File: rtl/ptg_cfg_track.sv
module ptg_cfg_track
    import ptg_pkg::*;
#(
    parameter int unsigned NUM_CH  = 5,
    parameter int unsigned PRE_W   = 8,
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned SPLIT   = 2,
    parameter int unsigned RST_PRE = 'h0101,
    parameter int unsigned RST_SEL = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2*PRE_W-1:0]        pre_i,
    input  logic [NUM_CH*SEL_W-1:0]   sel_i,
    output logic [NUM_CH*SEL_W-1:0]   sel_q,
    output logic [1:0]                pre_restart_o,
    output logic [NUM_CH-1:0]         ch_restart_o
);
    localparam int unsigned PW = 2 * PRE_W;
    localparam int unsigned SW = NUM_CH * SEL_W;

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= PW'(RST_PRE);
            sel_q <= SW'(RST_SEL);
        end else begin
            pre_q <= pre_i;
            sel_q <= sel_i;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_grp
        assign pre_restart_o[g] = (pre_i[g*PRE_W +: PRE_W] != pre_q[g*PRE_W +: PRE_W]);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int unsigned G = group_of(c, SPLIT);
        assign ch_restart_o[c] = pre_restart_o[G]
                               | (sel_i[c*SEL_W +: SEL_W] != sel_q[c*SEL_W +: SEL_W]);
    end

endmodule

// File: rtl/ptg_presc_fsm.sv
module ptg_presc_fsm
    import ptg_pkg::*;
#(
    parameter int unsigned PRE_W   = 8,
    parameter int unsigned RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             pulse_o
);
    ps_state_e        state_q, state_d;
    logic [PRE_W-1:0] rem_q, rem_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_COUNT;
            rem_q   <= PRE_W'(RST_VAL);
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        if (restart_i) begin
            rem_d   = div_i;
            state_d = (div_i == '0) ? PS_WRAP : PS_COUNT;
        end else begin
            unique case (state_q)
                PS_COUNT: begin
                    if (rem_q <= PRE_W'(1)) begin
                        state_d = PS_WRAP;
                        rem_d   = '0;
                    end else begin
                        rem_d   = rem_q - PRE_W'(1);
                    end
                end
                PS_WRAP: begin
                    rem_d   = div_i;
                    state_d = (div_i == '0) ? PS_WRAP : PS_COUNT;
                end
                default: begin
                    state_d = PS_COUNT;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        pulse_o = (state_q == PS_WRAP);
    end

endmodule

// File: rtl/ptg_chan_div.sv
module ptg_chan_div #(
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             pre_pulse_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int unsigned CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (pre_pulse_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        mask   = (CNT_W'(1) << sel_i) - CNT_W'(1);
        tick_o = pre_pulse_i && ((cnt_q & mask) == mask);
    end

endmodule

// File: rtl/prescaler_tick_gen.sv
module prescaler_tick_gen
    import ptg_pkg::*;
#(
    parameter int unsigned NUM_CH  = 5,
    parameter int unsigned PRE_W   = 8,
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned SPLIT   = 2,
    parameter int unsigned RST_PRE = 'h0101,
    parameter int unsigned RST_SEL = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2*PRE_W-1:0]        cfg_prescale_i,
    input  logic [NUM_CH*SEL_W-1:0]   cfg_select_i,
    output logic [NUM_CH-1:0]         tick_o
);
    localparam int unsigned PRE_MASK = (1 << PRE_W) - 1;

    logic [NUM_CH*SEL_W-1:0] sel_q;
    logic [1:0]              pre_restart;
    logic [NUM_CH-1:0]       ch_restart;
    logic [1:0]              pre_pulse;

    ptg_cfg_track #(
        .NUM_CH  (NUM_CH),
        .PRE_W   (PRE_W),
        .SEL_W   (SEL_W),
        .SPLIT   (SPLIT),
        .RST_PRE (RST_PRE),
        .RST_SEL (RST_SEL)
    ) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .pre_i         (cfg_prescale_i),
        .sel_i         (cfg_select_i),
        .sel_q         (sel_q),
        .pre_restart_o (pre_restart),
        .ch_restart_o  (ch_restart)
    );

    for (genvar g = 0; g < 2; g++) begin : g_pre
        ptg_presc_fsm #(
            .PRE_W   (PRE_W),
            .RST_VAL ((RST_PRE >> (g*PRE_W)) & PRE_MASK)
        ) u_pre (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (pre_restart[g]),
            .div_i     (cfg_prescale_i[g*PRE_W +: PRE_W]),
            .pulse_o   (pre_pulse[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int unsigned G = group_of(c, SPLIT);
        ptg_chan_div #(
            .SEL_W (SEL_W)
        ) u_div (
            .clk         (clk),
            .rst_n       (rst_n),
            .restart_i   (ch_restart[c]),
            .pre_pulse_i (pre_pulse[G]),
            .sel_i       (sel_q[c*SEL_W +: SEL_W]),
            .tick_o      (tick_o[c])
        );
    end

endmodule

// File: rtl/prescaler_tick_gen_chk.sv
module prescaler_tick_gen_chk
    import ptg_pkg::*;
#(
    parameter int unsigned NUM_CH = 5,
    parameter int unsigned PRE_W  = 8,
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned SPLIT  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2*PRE_W-1:0]      cfg_prescale_i,
    input logic [NUM_CH*SEL_W-1:0] sel_q,
    input logic [1:0]              pre_restart,
    input logic [1:0]              pre_pulse,
    input logic [NUM_CH-1:0]       tick_o
);
    p_quiet_in_reset_r1: assert property (@(posedge clk) !rst_n |-> (tick_o == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int unsigned G = group_of(c, SPLIT);

        p_tick_on_group_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o[c] |-> pre_pulse[G]);

        p_sel_zero_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_pulse[G] && (sel_q[c*SEL_W +: SEL_W] == '0)) |-> tick_o[c]);
    end

    for (genvar g = 0; g < 2; g++) begin : g_grp
        p_pulse_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_pulse[g] && !pre_restart[g] && (cfg_prescale_i[g*PRE_W +: PRE_W] != '0))
            |=> !pre_pulse[g]);

        p_restart_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_restart[g] && (cfg_prescale_i[g*PRE_W +: PRE_W] != '0))
            |=> !pre_pulse[g]);
    end

endmodule

bind prescaler_tick_gen prescaler_tick_gen_chk #(
    .NUM_CH (NUM_CH),
    .PRE_W  (PRE_W),
    .SEL_W  (SEL_W),
    .SPLIT  (SPLIT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_prescale_i (cfg_prescale_i),
    .sel_q          (sel_q),
    .pre_restart    (pre_restart),
    .pre_pulse      (pre_pulse),
    .tick_o         (tick_o)
);

// File: tb/test_prescaler_tick_gen.sv
`timescale 1ns/1ps
module test_prescaler_tick_gen;
    localparam int NCH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_pre = 16'h0101;
    logic [19:0] cfg_sel = 20'h0;
    logic [4:0]  tick;

    always #2.5 clk = ~clk;

    prescaler_tick_gen i_prescaler_tick_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_prescale_i (cfg_pre),
        .cfg_select_i   (cfg_sel),
        .tick_o         (tick)
    );

    int     checks = 0;
    int     fails  = 0;
    bit     done   = 1'b0;
    longint gcyc   = 0;
    longint last_tick [NCH];
    logic [15:0] cur_pre = 16'h0101;
    logic [19:0] cur_sel = 20'h0;

    function automatic longint period_of(int ch, logic [15:0] p, logic [19:0] s);
        longint pre;
        longint n;
        pre = (ch < 2) ? longint'(p[7:0]) : longint'(p[15:8]);
        n   = longint'(s[4*ch +: 4]);
        return (pre + 1) << n;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // apply a configuration just after a falling edge and watch W samples
    // kind: 0 unchanged, 1 prescaler restart, 2 select-only restart
    task automatic apply_watch(logic [15:0] np, logic [19:0] ns, longint W, bit after_reset);
        int     kind [NCH];
        longint per  [NCH];
        longint prev [NCH];
        longint first[NCH];
        longint gap0 [NCH];
        longint ntick[NCH];
        longint badv [NCH];
        int     bad  [NCH];
        for (int c = 0; c < NCH; c++) begin
            bit pch;
            pch = (c < 2) ? (np[7:0] != cur_pre[7:0]) : (np[15:8] != cur_pre[15:8]);
            if (pch) kind[c] = 1;
            else if (ns[4*c +: 4] != cur_sel[4*c +: 4]) kind[c] = 2;
            else kind[c] = 0;
            per[c]   = period_of(c, np, ns);
            prev[c]  = (kind[c] == 0 && !after_reset) ? last_tick[c] : -1;
            first[c] = -1;
            gap0[c]  = -1;
            ntick[c] = 0;
            bad[c]   = 0;
            badv[c]  = 0;
        end
        cfg_pre = np;
        cfg_sel = ns;
        cur_pre = np;
        cur_sel = ns;
        for (longint t = 1; t <= W; t++) begin
            @(negedge clk);
            gcyc++;
            for (int c = 0; c < NCH; c++) begin
                if (tick[c]) begin
                    if (prev[c] >= 0 && (gcyc - prev[c]) != per[c]) begin
                        bad[c]++;
                        badv[c] = gcyc - prev[c];
                    end
                    if (first[c] < 0) begin
                        first[c] = t;
                        if (prev[c] >= 0) gap0[c] = gcyc - prev[c];
                    end
                    ntick[c]++;
                    prev[c] = gcyc;
                    last_tick[c] = gcyc;
                end
            end
        end
        for (int c = 0; c < NCH; c++) begin
            // R2 R3: period depends on the group's prescaler field and the channel's own select field
            check(bad[c] == 0 && ntick[c] >= 2, "R4", $sformatf("ch%0d interval", c),
                  (bad[c] != 0) ? badv[c] : ntick[c], (bad[c] != 0) ? per[c] : 2);
            if (after_reset)
                check(first[c] == 1, "R8", $sformatf("ch%0d first tick after release", c), first[c], 1);
            else if (kind[c] == 1)
                check(first[c] == per[c], "R5", $sformatf("ch%0d first tick after prescaler change", c),
                      first[c], per[c]);
            else if (kind[c] == 2)
                check(first[c] >= 1 && first[c] <= per[c], "R6",
                      $sformatf("ch%0d first tick after select change", c), first[c], per[c]);
            else
                check(gap0[c] == per[c], "R7", $sformatf("ch%0d gap across change", c), gap0[c], per[c]);
        end
    endtask

    initial begin
        int quiet_bad;
        for (int c = 0; c < NCH; c++) last_tick[c] = -1;
        quiet_bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (tick != 5'b0) quiet_bad++;
        end
        check(quiet_bad == 0, "R1", "ticks during reset", quiet_bad, 0);
        rst_n = 1'b1;
        // R8: defaults held, period 2 from the first cycle
        apply_watch(16'h0101, 20'h0, 10, 1'b1);

        // R2 R3 R4 R5 R6: sweep of prescaler pairs and per-channel selects
        begin
            int pa [4] = '{0, 1, 2, 5};
            int pb [4] = '{0, 3, 1, 4};
            for (int ia = 0; ia < 4; ia++) begin
                for (int ib = 0; ib < 4; ib++) begin
                    logic [19:0] s;
                    s = '0;
                    for (int c = 0; c < NCH; c++) s[4*c +: 4] = 4'((ia + ib + c) % 5);
                    apply_watch({8'(pb[ib]), 8'(pa[ia])}, s, 194, 1'b0);
                end
            end
        end

        // R7: change only prescaler B; channels 0 and 1 keep cadence
        apply_watch({8'd2, cur_pre[7:0]}, cur_sel, 194, 1'b0);
        // R6: change only channel 3 select
        apply_watch(cur_pre, {cur_sel[19:16], 4'((cur_sel[15:12] + 4'd1) % 5), cur_sel[11:0]}, 194, 1'b0);
        // R3: largest selects
        apply_watch(16'h0300, 20'h0001E_F ^ 20'h0, 65540, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule